// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the settings of a clock synthesizer: a 9-bit feedback divide value, a 3-bit output divide code and a 2-bit test-select code. The settings come from one of two sources. The first is a parallel word that passes straight through while the parallel strobe is low and is frozen when that strobe rises. The second is a 14-bit serial stream that is shifted in on a serial clock and committed by a serial load strobe. The test-select code chooses what a test pin shows: a constant low, the last serial bit shifted in, the feedback divider output, or the synthesized clock.

All three strobes and the serial data arrive without a relation to the fast system clock. Each one passes through a synchronizer of the same depth, so they stay aligned. Edges are then found in the system clock domain. The PLL, the oscillator and the analog outputs are outside this block.

Top module: `divcfg_loader`

## Requirements
- R1: While `rst_n` is low, the block settles to `fb_div` = 200, `out_div` = 0, `test_sel` = 0 and `test_pin` = 0.
- R2: While `par_strobe` is low, `fb_div` and `out_div` follow `par_fb` and `par_out`. A change shows one system clock after it is sampled. `test_sel` is not changed.
- R3: When `par_strobe` rises, the parallel values present at that moment are captured. Later changes on `par_fb` and `par_out` have no effect while `par_strobe` stays high.
- R4: With `par_strobe` high and `ser_load` low, each rising `ser_clk` shifts `ser_data` into a 14-bit register, and the held settings do not change. The first bit of a frame lands in bit 13 and the last bit in bit 0.
- R5: A rising `ser_load` with `par_strobe` high copies the shift register to the settings. Bits 13:12 go to `test_sel` (the first bit shifted is the MSB), bits 11:9 go to `out_div` and bits 8:0 go to `fb_div`.
- R6: A falling `ser_load` leaves the settings as they are.
- R7: While `ser_load` stays high and `par_strobe` is high, each rising `ser_clk` shifts one bit and copies the new shift register contents to the settings.
- R8: Serial clocks and serial loads that occur while `par_strobe` is low change neither the shift register nor the settings.
- R9: With `par_strobe` high and `mreset` low, `test_pin` depends on `test_sel`. Code 0 drives low. Code 1 shows bit 0 of the shift register (the last serial bit clocked in). Code 2 shows `mdiv_fb`. Code 3 shows `synth_clk`.
- R10: `test_pin` is low while `par_strobe` is low, whatever the value of `test_sel`.
- R11: `mreset` high forces `test_pin` low and leaves `fb_div`, `out_div` and `test_sel` unchanged.
- R12: When `ser_clk` and `ser_load` rise in the same system clock cycle, the bit is shifted first. The settings then receive the shifted contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mreset | input | 1 | Master reset; silences the test pin |
| par_fb | input | 9 | Parallel feedback divide value |
| par_out | input | 3 | Parallel output divide code |
| par_strobe | input | 1 | Parallel strobe; low = transparent, rising = capture |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial commit strobe |
| mdiv_fb | input | 1 | Feedback divider output, for the test pin |
| synth_clk | input | 1 | Synthesized clock, for the test pin |
| fb_div | output | 9 | Active feedback divide value |
| out_div | output | 3 | Active output divide code |
| test_sel | output | 2 | Active test-select code |
| test_pin | output | 1 | Test multiplexer output |

## Verification
The parallel path is swept over all 512 feedback values, with the output code tied to the low bits. This catches any dropped or swapped bit on the transparent path. A walking-one frame across all 14 serial positions shows that each frame bit reaches its own field, and a set of mixed frames covers all four test codes. Edge-order cases are tried separately: a load held high while clocking, a load falling, serial activity during parallel mode, and a clock and load rising together. Each case gives a different expected setting, so a wrong ordering is detected.

// File: rtl/divcfg_pkg.sv
// Shared widths and types for the divider configuration loader.
// Assumes the frame order: test bits (MSB), output code, feedback value.
package divcfg_pkg;
    localparam int FB_W  = 9;
    localparam int OUT_W = 3;
    localparam int SEL_W = 2;
    localparam int FRAME_W = FB_W + OUT_W + SEL_W;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [OUT_W-1:0] odiv;
        logic [FB_W-1:0]  fdiv;
    } cfg_word_t;

    typedef enum logic [SEL_W-1:0] {
        TST_LOW   = 2'd0,
        TST_SDATA = 2'd1,
        TST_MDIV  = 2'd2,
        TST_SYNTH = 2'd3
    } test_mode_e;
endpackage

// File: rtl/divcfg_sync.sv
// Flop chain that brings an asynchronous level into the clk domain.
// Assumes STAGES >= 1; every chain in the block uses the same depth so
// that the signals stay aligned.
module divcfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one synchronizer stage.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[g] <= 1'b0;
                else if (g == 0)
                    chain[g] <= async_in;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/divcfg_edge.sv
// Synchronizes one strobe and reports its level and its rise and fall
// edges. Assumes each strobe level lasts longer than one clk period.
module divcfg_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic prev;

    divcfg_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(async_in), .sync_out(level)
    );

    // Purpose: remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
    end

    assign rise = level & ~prev;
    assign fall = ~level & prev;
endmodule

// File: rtl/divcfg_shift.sv
// Serial frame shift register. The newest bit enters at bit 0.
// Gives both the present and the next contents, so that a load in the
// same cycle as a shift can see the shifted word.
module divcfg_shift #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);
    assign q_next = shift_en ? {q[W-2:0], din} : q;

    // Purpose: hold the frame being shifted in.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    assert_shift_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> q[0] == $past(din));
endmodule

// File: rtl/divcfg_regs.sv
// Active divider settings. The parallel path has priority and never
// touches the test code; the serial path writes the whole word.
module divcfg_regs
    import divcfg_pkg::*;
#(
    parameter logic [FB_W-1:0]  FB_DEFAULT  = 9'd200,
    parameter logic [OUT_W-1:0] OUT_DEFAULT = 3'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_lvl,
    input  logic             par_rise,
    input  logic [FB_W-1:0]  par_fb,
    input  logic [OUT_W-1:0] par_out,
    input  logic             ser_wr,
    input  cfg_word_t        ser_word,
    output cfg_word_t        cfg
);
    // Purpose: update the settings from the parallel or the serial source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.sel  <= TST_LOW;
            cfg.odiv <= OUT_DEFAULT;
            cfg.fdiv <= FB_DEFAULT;
        end else if (!par_lvl || par_rise) begin
            cfg.fdiv <= par_fb;
            cfg.odiv <= par_out;
        end else if (ser_wr) begin
            cfg <= ser_word;
        end
    end
endmodule

// File: rtl/divcfg_tmux.sv
// Test pin multiplexer. It is silent in parallel mode and under master
// reset.
module divcfg_tmux
    import divcfg_pkg::*;
(
    input  logic             par_lvl,
    input  logic             mreset,
    input  logic [SEL_W-1:0] sel,
    input  logic             last_bit,
    input  logic             mdiv_fb,
    input  logic             synth_clk,
    output logic             test_pin
);
    // Purpose: choose the test source from the selection code.
    always_comb begin
        test_pin = 1'b0;
        if (par_lvl && !mreset) begin
            case (test_mode_e'(sel))
                TST_SDATA: test_pin = last_bit;
                TST_MDIV:  test_pin = mdiv_fb;
                TST_SYNTH: test_pin = synth_clk;
                default:   test_pin = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/divcfg_loader.sv
// Top level of the divider configuration loader. It synchronizes the
// strobes and the serial data through chains of equal depth, finds their
// edges, and drives the shift register, the settings and the test
// multiplexer. Assumes the parallel data is stable around a rising
// par_strobe.
module divcfg_loader
    import divcfg_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [FB_W-1:0]  FB_DEFAULT  = 9'd200,
    parameter logic [OUT_W-1:0] OUT_DEFAULT = 3'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mreset,
    input  logic [FB_W-1:0]  par_fb,
    input  logic [OUT_W-1:0] par_out,
    input  logic             par_strobe,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_load,
    input  logic             mdiv_fb,
    input  logic             synth_clk,
    output logic [FB_W-1:0]  fb_div,
    output logic [OUT_W-1:0] out_div,
    output logic [SEL_W-1:0] test_sel,
    output logic             test_pin
);
    logic pl_lvl, pl_rise, pl_fall;
    logic sc_lvl, sc_rise, sc_fall;
    logic sl_lvl, sl_rise, sl_fall;
    logic sd_sync;
    logic shift_en, ser_wr;
    logic [FRAME_W-1:0] sr_q, sr_next;
    cfg_word_t cfg;

    divcfg_edge #(.STAGES(SYNC_STAGES)) u_pl (
        .clk(clk), .rst_n(rst_n), .async_in(par_strobe),
        .level(pl_lvl), .rise(pl_rise), .fall(pl_fall));
    divcfg_edge #(.STAGES(SYNC_STAGES)) u_sc (
        .clk(clk), .rst_n(rst_n), .async_in(ser_clk),
        .level(sc_lvl), .rise(sc_rise), .fall(sc_fall));
    divcfg_edge #(.STAGES(SYNC_STAGES)) u_sl (
        .clk(clk), .rst_n(rst_n), .async_in(ser_load),
        .level(sl_lvl), .rise(sl_rise), .fall(sl_fall));
    divcfg_sync #(.STAGES(SYNC_STAGES)) u_sd (
        .clk(clk), .rst_n(rst_n), .async_in(ser_data), .sync_out(sd_sync));

    // Serial events count only in serial mode; a clock edge is applied
    // before a load in the same cycle.
    assign shift_en = pl_lvl & sc_rise;
    assign ser_wr   = pl_lvl & sl_lvl & (sl_rise | sc_rise);

    divcfg_shift #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(sd_sync),
        .q(sr_q), .q_next(sr_next));

    divcfg_regs #(.FB_DEFAULT(FB_DEFAULT), .OUT_DEFAULT(OUT_DEFAULT)) u_regs (
        .clk(clk), .rst_n(rst_n), .par_lvl(pl_lvl), .par_rise(pl_rise),
        .par_fb(par_fb), .par_out(par_out), .ser_wr(ser_wr),
        .ser_word(cfg_word_t'(sr_next)), .cfg(cfg));

    divcfg_tmux u_tmux (
        .par_lvl(pl_lvl), .mreset(mreset), .sel(cfg.sel), .last_bit(sr_q[0]),
        .mdiv_fb(mdiv_fb), .synth_clk(synth_clk), .test_pin(test_pin));

    assign fb_div   = cfg.fdiv;
    assign out_div  = cfg.odiv;
    assign test_sel = cfg.sel;

    assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_lvl |=> (fb_div == $past(par_fb)) && (out_div == $past(par_out)));
    assert_shift_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_lvl && !pl_rise && !sl_lvl) |=> $stable(cfg));
    assert_load_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_lvl && !pl_rise && sl_rise) |=> cfg == $past(sr_next));
    assert_fall_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_lvl && !pl_rise && sl_fall) |=> $stable(cfg));
    assert_par_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_lvl |-> !test_pin);
    assert_mreset_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |-> !test_pin);
    assert_ignore_ser_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_lvl |=> $stable(sr_q));
endmodule

// File: tb/divcfg_loader_test.sv
module divcfg_loader_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mreset = 1'b0;
    logic [8:0] par_fb = 9'd77;
    logic [2:0] par_out = 3'd5;
    logic par_strobe = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic mdiv_fb = 1'b0, synth_clk = 1'b0;
    logic [8:0] fb_div;
    logic [2:0] out_div;
    logic [1:0] test_sel;
    logic test_pin;
    int checks = 0, errors = 0;
    logic done = 1'b0;
    logic [13:0] shadow = '0;   // expected shift register contents
    logic [13:0] held;          // expected held settings {sel,odiv,fdiv}

    always #2.5 clk = ~clk;

    divcfg_loader uut (
        .clk(clk), .rst_n(rst_n), .mreset(mreset), .par_fb(par_fb),
        .par_out(par_out), .par_strobe(par_strobe), .ser_clk(ser_clk),
        .ser_data(ser_data), .ser_load(ser_load), .mdiv_fb(mdiv_fb),
        .synth_clk(synth_clk), .fb_div(fb_div), .out_div(out_div),
        .test_sel(test_sel), .test_pin(test_pin));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_cfg(input string req, input logic [13:0] exp);
        chk(req, int'({test_sel, out_div, fb_div}), int'(exp));
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ser_bit(input logic b);
        ser_data = b; wcyc(4);
        ser_clk = 1'b1; wcyc(4);
        ser_clk = 1'b0; wcyc(4);
        shadow = {shadow[12:0], b};
    endtask

    task automatic send_frame(input logic [13:0] f);
        for (int i = 13; i >= 0; i--) ser_bit(f[i]);
    endtask

    task automatic pulse_load();
        ser_load = 1'b1; wcyc(6);
        ser_load = 1'b0; wcyc(6);
    endtask

    initial begin
        #(5ns * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wcyc(4);
        // R1: state while reset is held
        chk("R1 fb", fb_div, 200);
        chk("R1 out", out_div, 0);
        chk("R1 sel", test_sel, 0);
        chk("R1 pin", test_pin, 0);
        rst_n = 1'b1; wcyc(2);

        // R2: full sweep of the transparent parallel path
        for (int m = 0; m < 512; m++) begin
            par_fb = 9'(m); par_out = 3'(m % 8);
            wcyc(1);
            chk("R2", int'({out_div, fb_div}), int'({3'(m % 8), 9'(m)}));
        end
        chk("R2 sel kept", test_sel, 0);

        // R3: capture on the parallel rise, later changes ignored
        par_fb = 9'd300; par_out = 3'd3; wcyc(2);
        par_strobe = 1'b1; wcyc(6);
        par_fb = 9'd17; par_out = 3'd6; wcyc(5);
        chk_cfg("R3", {2'd0, 3'd3, 9'd300});
        held = {2'd0, 3'd3, 9'd300};

        // R4 and R5: walking one through all frame positions
        for (int k = 0; k < 14; k++) begin
            send_frame(14'(1) << k);
            chk_cfg("R4 hold", held);
            pulse_load();
            held = 14'(1) << k;
            chk_cfg("R5 walk", held);
            chk("R6 after fall", int'({test_sel, out_div, fb_div}), int'(held));
        end

        // R5 and R9: mixed frames over all test codes
        for (int j = 0; j < 8; j++) begin
            logic [13:0] f;
            f = {2'(j % 4), 3'(j * 3), 9'(125 + j * 29)};
            send_frame(f);
            pulse_load();
            chk_cfg("R5 frame", f);
            for (int v = 0; v < 4; v++) begin
                mdiv_fb = v[0]; synth_clk = v[1]; wcyc(1);
                case (j % 4)
                    0: chk("R9 low", test_pin, 0);
                    1: chk("R9 sdata", test_pin, int'(f[0]));
                    2: chk("R9 mdiv", test_pin, v[0]);
                    default: chk("R9 synth", test_pin, v[1]);
                endcase
            end
        end
        // R9: code 1 follows a new bit without touching settings
        send_frame({2'd1, 3'd2, 9'd200}); pulse_load();
        held = {2'd1, 3'd2, 9'd200};
        ser_bit(1'b1);
        chk("R9 new bit", test_pin, 1);
        chk_cfg("R4 one bit", held);
        ser_bit(1'b0);
        chk("R9 new bit0", test_pin, 0);

        // R11: master reset silences test pin, keeps settings
        send_frame({2'd3, 3'd4, 9'd250}); pulse_load();
        held = {2'd3, 3'd4, 9'd250};
        synth_clk = 1'b1; wcyc(1);
        chk("R9 synth hi", test_pin, 1);
        mreset = 1'b1; wcyc(3);
        chk("R11 pin", test_pin, 0);
        chk_cfg("R11 cfg", held);
        mreset = 1'b0; wcyc(1);
        chk("R11 release", test_pin, 1);

        // R7: load held high, each clock updates the settings
        ser_load = 1'b1; wcyc(6);
        chk_cfg("R7 rise", shadow);
        ser_bit(1'b1);
        chk_cfg("R7 bit1", shadow);
        ser_bit(1'b0);
        chk_cfg("R7 bit2", shadow);
        ser_load = 1'b0; wcyc(6);
        chk_cfg("R6 fall", shadow);
        held = shadow;

        // R12: clock and load rising in the same cycle
        ser_data = 1'b1; wcyc(4);
        ser_clk = 1'b1; ser_load = 1'b1; wcyc(6);
        shadow = {shadow[12:0], 1'b1};
        chk_cfg("R12", shadow);
        ser_clk = 1'b0; wcyc(4);
        ser_load = 1'b0; wcyc(6);
        held = shadow;

        // R10: parallel mode silences test pin (code 3, synth high)
        synth_clk = 1'b1;
        send_frame({2'd3, 3'd1, 9'd333}); pulse_load();
        chk("R10 before", test_pin, 1);
        par_fb = 9'd150; par_out = 3'd2;
        par_strobe = 1'b0; wcyc(4);
        chk("R10 pin", test_pin, 0);
        chk_cfg("R2 again", {2'd3, 3'd2, 9'd150});

        // R8: serial activity in parallel mode is ignored
        held = shadow;
        for (int i = 13; i >= 0; i--) begin
            ser_data = ~held[i]; wcyc(4);
            ser_clk = 1'b1; wcyc(4);
            ser_clk = 1'b0; wcyc(4);
        end
        pulse_load();
        chk_cfg("R8 par", {2'd3, 3'd2, 9'd150});
        par_strobe = 1'b1; wcyc(6);
        pulse_load();
        chk_cfg("R8 old frame", held);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule